// File: doc/BRIEF.md
# Per-Bit Read Eye Centering Engine

This engine calibrates the read sampling delay of every data bit on a wide DDR-style read interface. It takes one lane at a time. For that lane it steps a delay tap upward from the lowest setting to the highest. At each tap it issues a burst of reads whose expected data comes from a pseudo-random sequence. The captured bit is compared against that expected data on every read. A tap counts as passing only when the whole burst matches.

While the sweep runs, the engine tracks the longest unbroken stretch of passing taps. When the highest tap has been evaluated, it takes the midpoint of that stretch as the sampling point. This point has equal margin to both edges. The engine reports it and stores it in a per-lane deskew register. A lane with no passing tap is flagged as failed.

The delay line, the memory and the read path are abstracted as two signals. The engine drives a tap value and receives a captured bit back in the same cycle. The default configuration covers 64 data bits plus 8 check bits, which is 72 lanes.

Top module: `read_eye_center`

## Requirements
- R1: A `start` pulse while idle begins a calibration run. `busy` stays high until the run ends. Lanes are calibrated one after another from 0 to NUM_BITS-1, and `lane_sel` shows the lane under test.
- R2: For each lane, `tap_sel` steps through 0 to 63 in ascending order. At each tap there are exactly 64 consecutive cycles with `rd_en` high, with `tap_sel` and `lane_sel` held constant. One cycle with `rd_en` low follows each burst.
- R3: `pat_bit` is the most significant bit of a 31-bit shift register. The register is loaded with all ones before the first read of every tap. After each read it shifts left, and the new bit 0 is state[30] XOR state[27].
- R4: A tap passes only if `cap_bit` equals `pat_bit` on all 64 reads of its burst. A single mismatching read fails the tap.
- R5: The passing window is the longest contiguous run of passing taps. When two runs have equal length, the one starting at the lower tap is chosen.
- R6: The sampling point is (left + right) / 2 rounded down, where left and right are the window's end taps. It is shown on `res_tap` during a one-cycle `res_valid` pulse, with `lane_sel` giving the lane. From the next cycle it appears in `deskew_flat` bits [lane*6 +: 6].
- R7: A lane with no passing tap reports `res_err` = 1 with `res_tap` = 0. It then has `err_flags[lane]` = 1 and a stored deskew of 0. A later run that finds a window clears that flag.
- R8: After reset, `busy`, `done`, `rd_en` and `res_valid` are low, and `deskew_flat` and `err_flags` are zero. A `start` pulse during a run is ignored.
- R9: `done` pulses high for exactly one cycle, one cycle after the last lane's `res_valid`. `busy` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a calibration run (sampled while idle) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| lane_sel | output | $clog2(NUM_BITS) | Lane under calibration |
| tap_sel | output | TAP_W | Delay tap applied to the selected lane |
| rd_en | output | 1 | A test read is taking place this cycle |
| pat_bit | output | 1 | Expected data bit of the current read |
| cap_bit | input | 1 | Captured data bit of the current read |
| res_valid | output | 1 | Result for `lane_sel` is on `res_tap`/`res_err` |
| res_tap | output | TAP_W | Chosen sampling tap |
| res_err | output | 1 | No passing tap was found |
| deskew_flat | output | NUM_BITS*TAP_W | Stored sampling tap of every lane |
| err_flags | output | NUM_BITS | Failed-lane flags |

## Verification
Three kinds of internal fault show up at the ports in different ways. A wrong run or best-window record does not show during the sweep. It becomes visible only at the lane's `res_valid` cycle, as a wrong `res_tap`, so the test eyes are shaped to expose it: split windows, equal-length ties, windows touching either end of the tap range, and empty lanes. A wrong burst counter or a wrong shift register shows on the very next read, because the bench follows `tap_sel`, `rd_en` and `pat_bit` on every cycle with its own model. A missed mismatch is revealed by a single corrupted read at the end of one burst, which must split a window in two.

// File: rtl/rec_pkg.sv
// Shared types for the read eye centering engine.
// Assumes: nothing beyond IEEE 1800-2017.
package rec_pkg;

    // Sequencer states of the calibration run
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SWEEP,
        ST_EVAL,
        ST_WRITE,
        ST_DONE
    } cal_state_t;

endpackage

// File: rtl/rec_prbs.sv
// Pattern source: Fibonacci shift register whose top bit is the expected data.
// Assumes ORDER is 23 (taps 23,18) or 31 (taps 31,28); the seed is all ones.
module rec_prbs #(
    parameter int ORDER = 31
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reseed,
    input  logic advance,
    output logic bit_o
);
    localparam logic [ORDER-1:0] SEED = {ORDER{1'b1}};

    logic [ORDER-1:0] st;
    logic             fb;

    // Feedback taps picked by the sequence order
    generate
        if (ORDER == 23) begin : g_p23
            assign fb = st[22] ^ st[17];
        end else begin : g_p31
            assign fb = st[ORDER-1] ^ st[27];
        end
    endgenerate

    // Load the seed or step the sequence once per read
    always_ff @(posedge clk) begin
        if (!rst_n)       st <= SEED;
        else if (reseed)  st <= SEED;
        else if (advance) st <= {st[ORDER-2:0], fb};
    end

    assign bit_o = st[ORDER-1];
endmodule

// File: rtl/rec_window.sv
// Passing-window tracker: keeps the current passing run and the longest one
// seen so far (first one wins a tie) and gives the floored window midpoint.
// Assumes taps are evaluated in ascending order after each clear.
module rec_window #(
    parameter int TAP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             eval,
    input  logic             pass,
    input  logic [TAP_W-1:0] tap,
    output logic [TAP_W-1:0] mid,
    output logic             empty
);
    localparam int LEN_W = TAP_W + 1;

    logic [TAP_W-1:0] run_start, best_start, nxt_start;
    logic [LEN_W-1:0] run_len, best_len, nxt_len;
    logic [LEN_W-1:0] end_sum;

    // Extend or open the current run for a passing tap
    always_comb begin
        nxt_start = (run_len == '0) ? tap : run_start;
        nxt_len   = run_len + LEN_W'(1);
    end

    // Update run and best records at each evaluated tap
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            run_start  <= '0;
            run_len    <= '0;
            best_start <= '0;
            best_len   <= '0;
        end else if (eval) begin
            if (pass) begin
                run_start <= nxt_start;
                run_len   <= nxt_len;
                if (nxt_len > best_len) begin
                    best_start <= nxt_start;
                    best_len   <= nxt_len;
                end
            end else begin
                run_len <= '0;
            end
        end
    end

    // Midpoint: (left + right) / 2 rounded down
    always_comb begin
        end_sum = LEN_W'(best_start) + LEN_W'(best_start) + best_len - LEN_W'(1);
        empty   = (best_len == '0);
        mid     = empty ? '0 : TAP_W'(end_sum >> 1);
    end
endmodule

// File: rtl/rec_deskew_store.sv
// Per-lane result registers: one sampling tap and one fail flag per lane.
// Assumes addr < NUM_BITS whenever we is high.
module rec_deskew_store #(
    parameter int NUM_BITS = 72,
    parameter int TAP_W    = 6,
    localparam int BIT_W   = $clog2(NUM_BITS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [BIT_W-1:0]          addr,
    input  logic [TAP_W-1:0]          wdata,
    input  logic                      werr,
    output logic [NUM_BITS*TAP_W-1:0] flat,
    output logic [NUM_BITS-1:0]       errs
);
    generate
        for (genvar i = 0; i < NUM_BITS; i++) begin : g_lane
            logic [TAP_W-1:0] tap_q;
            logic             err_q;

            // Capture this lane's result when it is written
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tap_q <= '0;
                    err_q <= 1'b0;
                end else if (we && addr == BIT_W'(i)) begin
                    tap_q <= wdata;
                    err_q <= werr;
                end
            end

            assign flat[i*TAP_W +: TAP_W] = tap_q;
            assign errs[i]                = err_q;
        end
    endgenerate
endmodule

// File: rtl/read_eye_center.sv
// Read eye centering engine, top level. Sequences lanes and taps, runs a
// burst of pattern reads per tap, judges the tap and stores each lane's
// window midpoint. Assumes cap_bit answers the read of the same cycle.
module read_eye_center #(
    parameter int NUM_BITS   = 72,
    parameter int TAP_W      = 6,
    parameter int BURST_LEN  = 64,
    parameter int PRBS_ORDER = 31,
    localparam int BIT_W     = $clog2(NUM_BITS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    output logic                      busy,
    output logic                      done,
    output logic [BIT_W-1:0]          lane_sel,
    output logic [TAP_W-1:0]          tap_sel,
    output logic                      rd_en,
    output logic                      pat_bit,
    input  logic                      cap_bit,
    output logic                      res_valid,
    output logic [TAP_W-1:0]          res_tap,
    output logic                      res_err,
    output logic [NUM_BITS*TAP_W-1:0] deskew_flat,
    output logic [NUM_BITS-1:0]       err_flags
);
    import rec_pkg::*;

    localparam int CNT_W = $clog2(BURST_LEN);
    localparam logic [TAP_W-1:0] TAP_LAST  = {TAP_W{1'b1}};
    localparam logic [BIT_W-1:0] LANE_LAST = BIT_W'(NUM_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(BURST_LEN - 1);

    cal_state_t       state;
    logic [BIT_W-1:0] lane;
    logic [TAP_W-1:0] tap;
    logic [CNT_W-1:0] rd_cnt;
    logic             miss;
    logic             go, win_clear, reseed;
    logic [TAP_W-1:0] mid;
    logic             empty;

    assign go        = (state == ST_IDLE) && start;
    assign win_clear = go || (state == ST_WRITE);
    assign reseed    = go || (state == ST_EVAL) || (state == ST_WRITE);

    // Sequencer: lane and tap stepping, burst counting, mismatch capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            lane   <= '0;
            tap    <= '0;
            rd_cnt <= '0;
            miss   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    lane   <= '0;
                    tap    <= '0;
                    rd_cnt <= '0;
                    miss   <= 1'b0;
                    state  <= ST_SWEEP;
                end
                ST_SWEEP: begin
                    miss   <= miss | (cap_bit != pat_bit);
                    rd_cnt <= rd_cnt + CNT_W'(1);
                    if (rd_cnt == CNT_LAST) state <= ST_EVAL;
                end
                ST_EVAL: begin
                    rd_cnt <= '0;
                    miss   <= 1'b0;
                    if (tap == TAP_LAST) begin
                        state <= ST_WRITE;
                    end else begin
                        tap   <= tap + TAP_W'(1);
                        state <= ST_SWEEP;
                    end
                end
                ST_WRITE: begin
                    tap <= '0;
                    if (lane == LANE_LAST) begin
                        state <= ST_DONE;
                    end else begin
                        lane  <= lane + BIT_W'(1);
                        state <= ST_SWEEP;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    rec_prbs #(.ORDER(PRBS_ORDER)) u_prbs (
        .clk    (clk),
        .rst_n  (rst_n),
        .reseed (reseed),
        .advance(rd_en),
        .bit_o  (pat_bit)
    );

    rec_window #(.TAP_W(TAP_W)) u_window (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(win_clear),
        .eval (state == ST_EVAL),
        .pass (!miss),
        .tap  (tap),
        .mid  (mid),
        .empty(empty)
    );

    rec_deskew_store #(.NUM_BITS(NUM_BITS), .TAP_W(TAP_W)) u_store (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (res_valid),
        .addr (lane),
        .wdata(mid),
        .werr (empty),
        .flat (deskew_flat),
        .errs (err_flags)
    );

    // Port views of the sequencer state
    always_comb begin
        busy      = (state != ST_IDLE);
        done      = (state == ST_DONE);
        rd_en     = (state == ST_SWEEP);
        res_valid = (state == ST_WRITE);
        res_tap   = mid;
        res_err   = empty;
        lane_sel  = lane;
        tap_sel   = tap;
    end
endmodule

// File: rtl/read_eye_center_chk.sv
// Property checker for read_eye_center, attached by bind below.
// Assumes the same parameters as the bound instance.
module read_eye_center_chk #(
    parameter int NUM_BITS = 72,
    parameter int TAP_W    = 6,
    localparam int BIT_W   = $clog2(NUM_BITS)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      busy,
    input logic                      done,
    input logic [BIT_W-1:0]          lane_sel,
    input logic [TAP_W-1:0]          tap_sel,
    input logic                      rd_en,
    input logic                      res_valid,
    input logic [TAP_W-1:0]          res_tap,
    input logic                      res_err,
    input logic [NUM_BITS*TAP_W-1:0] deskew_flat,
    input logic [NUM_BITS-1:0]       err_flags
);
    assert_read_in_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> busy);

    assert_burst_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> (tap_sel == $past(tap_sel) && lane_sel == $past(lane_sel)));

    assert_stored_tap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> deskew_flat[int'($past(lane_sel))*TAP_W +: TAP_W] == $past(res_tap));

    assert_empty_tap_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_err) |-> res_tap == '0);

    assert_stored_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> err_flags[$past(lane_sel)] == $past(res_err));

    assert_done_after_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!rd_en && !res_valid && $past(res_valid)));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
endmodule

bind read_eye_center read_eye_center_chk #(.NUM_BITS(NUM_BITS), .TAP_W(TAP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .lane_sel   (lane_sel),
    .tap_sel    (tap_sel),
    .rd_en      (rd_en),
    .res_valid  (res_valid),
    .res_tap    (res_tap),
    .res_err    (res_err),
    .deskew_flat(deskew_flat),
    .err_flags  (err_flags)
);

// File: tb/read_eye_center_test.sv
// Scoreboard bench: the driver pushes expected lane results, the monitor pops
// them at each res_valid; a read tracker follows taps and the pattern per read.
module read_eye_center_test;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 4;
    localparam int TW = 6;
    localparam int BL = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic busy, done, rd_en, pat_bit, cap_bit, res_valid, res_err;
    logic [1:0] lane_sel;
    logic [TW-1:0] tap_sel, res_tap;
    logic [NB*TW-1:0] deskew_flat;
    logic [NB-1:0] err_flags;

    read_eye_center #(.NUM_BITS(NB), .TAP_W(TW), .BURST_LEN(BL), .PRBS_ORDER(31)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .lane_sel(lane_sel), .tap_sel(tap_sel), .rd_en(rd_en), .pat_bit(pat_bit),
        .cap_bit(cap_bit), .res_valid(res_valid), .res_tap(res_tap), .res_err(res_err),
        .deskew_flat(deskew_flat), .err_flags(err_flags)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed { logic [1:0] lane; logic [5:0] tap; logic err; } exp_t;
    exp_t exp_q[$];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_res_cyc = 0;
    logic [63:0] eye_mask [NB];
    int g_en = 0, g_lane = 0, g_tap = 0;
    int rd_idx = 0;
    int bt_lane = 0, bt_tap = 0, bt_idx = 0;
    logic [30:0] lf = '1;
    int exp_desk [NB];
    bit exp_err [NB];

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // Read path model: bits outside the eye, and one injected read, come back inverted
    always_comb begin
        logic fail;
        fail = !eye_mask[lane_sel][tap_sel];
        if (g_en != 0 && int'(lane_sel) == g_lane && int'(tap_sel) == g_tap && rd_idx == BL-1)
            fail = 1'b1;
        cap_bit = pat_bit ^ fail;
    end

    // Index of the current read within its burst
    always @(posedge clk) begin
        cyc <= cyc + 1;
        rd_idx <= rd_en ? rd_idx + 1 : 0;
    end

    // Read tracker: tap order, burst length and expected pattern (R2, R3)
    always @(negedge clk) begin
        if (rst_n && rd_en) begin
            if (bt_idx == 0) lf = '1;
            chk(int'(lane_sel) == bt_lane, "R2 lane", int'(lane_sel), bt_lane);
            chk(int'(tap_sel) == bt_tap, "R2 tap", int'(tap_sel), bt_tap);
            chk(pat_bit == lf[30], "R3 pattern", int'(pat_bit), int'(lf[30]));
            lf = {lf[29:0], lf[30] ^ lf[27]};
            bt_idx++;
            if (bt_idx == BL) begin
                bt_idx = 0;
                if (bt_tap == 63) begin bt_tap = 0; bt_lane++; end
                else bt_tap++;
            end
        end else if (rst_n && bt_idx != 0) begin
            chk(1'b0, "R2 burst broken", bt_idx, BL);
            bt_idx = 0;
        end
    end

    // Monitor: pop and compare each lane result (R5, R6, R7)
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            last_res_cyc = cyc;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1 unexpected result", int'(lane_sel), -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(lane_sel == e.lane, "R1 result lane", int'(lane_sel), int'(e.lane));
                chk(res_tap == e.tap, "R5/R6 res_tap", int'(res_tap), int'(e.tap));
                chk(res_err == e.err, "R7 res_err", int'(res_err), int'(e.err));
            end
        end
    end

    // Expected midpoint: longest passing run, lowest start on a tie
    function automatic void calc(input logic [63:0] m, output int mid, output bit err);
        int bs = 0, bln = 0, rs = 0, rl = 0;
        for (int t = 0; t < 64; t++) begin
            if (m[t]) begin
                if (rl == 0) rs = t;
                rl++;
                if (rl > bln) begin bln = rl; bs = rs; end
            end else rl = 0;
        end
        err = (bln == 0);
        mid = err ? 0 : (bs + bs + bln - 1) / 2;
    endfunction

    function automatic logic [63:0] span(input int lo, input int hi);
        logic [63:0] m = '0;
        for (int t = lo; t <= hi; t++) m[t] = 1'b1;
        return m;
    endfunction

    // Driver: set eyes, push expected results, run and check the stored state
    task automatic run_cal(input logic [63:0] m0, m1, m2, m3,
                           input int gen, gl, gt, input bit poke_start);
        eye_mask[0] = m0; eye_mask[1] = m1; eye_mask[2] = m2; eye_mask[3] = m3;
        g_en = gen; g_lane = gl; g_tap = gt;
        for (int l = 0; l < NB; l++) begin
            logic [63:0] eff;
            int mid;
            bit err;
            exp_t e;
            eff = eye_mask[l];
            if (gen != 0 && gl == l) eff[gt] = 1'b0;
            calc(eff, mid, err);
            e.lane = 2'(l); e.tap = 6'(mid); e.err = err;
            exp_q.push_back(e);
            exp_desk[l] = mid; exp_err[l] = err;
        end
        bt_lane = 0; bt_tap = 0; bt_idx = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy == 1'b1, "R1 busy after start", int'(busy), 1);
        if (poke_start) begin
            repeat (5000) @(negedge clk);
            start = 1'b1;                       // R8: ignored while busy
            @(negedge clk) start = 1'b0;
        end
        while (!done) @(negedge clk);
        chk(cyc == last_res_cyc + 1, "R9 done timing", cyc, last_res_cyc + 1);
        chk(exp_q.size() == 0, "R1 all lanes reported", exp_q.size(), 0);
        chk(bt_lane == NB, "R1 lanes swept", bt_lane, NB);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R9 done one cycle", int'(done), 0);
        for (int l = 0; l < NB; l++) begin
            chk(int'(deskew_flat[l*TW +: TW]) == exp_desk[l], "R6 stored deskew",
                int'(deskew_flat[l*TW +: TW]), exp_desk[l]);
            chk(err_flags[l] == exp_err[l], "R7 stored flag", int'(err_flags[l]), int'(exp_err[l]));
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (120000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int l = 0; l < NB; l++) eye_mask[l] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !rd_en && !res_valid, "R8 reset outputs", int'(busy), 0);
        chk(deskew_flat == '0 && err_flags == '0, "R8 reset registers", int'(err_flags), 0);
        // Run 1: plain window, split windows, empty lane, fully open lane
        run_cal(span(10, 40), span(5, 9) | span(30, 50), '0, span(0, 63), 0, 0, 0, 0);
        // Run 2: R5 tie, top-edge window, R4 single bad read splitting a window,
        // one-tap window at zero, start pulse during the run (R8), flag cleared (R7)
        run_cal(span(0, 7) | span(20, 27), span(60, 63), span(20, 30), span(0, 0), 1, 2, 25, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule